// File: doc/BRIEF.md
# SPI EEPROM Status and Write-Protect Unit

This block is the status register and write-protection front end of a 1K x 8 serial EEPROM model. It is an SPI slave in mode 0, meaning data is sampled on rising SCK and driven on falling SCK. It accepts three instructions: a write-enable command, a status write followed by one data byte, and a status read that shifts the status byte out on SO.

From the two block-protect bits, a write-protect enable bit and an external write-protect pin, it decides two things. The first is whether a status write is accepted. The second is whether the array write path may write a given 10-bit address. The address is applied on a query port and the permit comes back combinationally.

The SPI pins are oversampled by the system clock, so the block lives entirely in one clock domain. A command takes effect when CS_n rises, and only if the frame had exactly the right length.

Top module: `spi_wp_unit`

## Requirements
- R1: Opcode 0x01 followed by one data byte (both MSB first, 16 rising SCK edges in total) commits the status bits when CS_n rises, provided the write-enable latch is set. WPEN is taken from data bit 7 and the block-protect code from data bits 3:2.
- R2: Opcode 0x06, sent with exactly 8 rising SCK edges, sets the write-enable latch when CS_n rises. A committed status write clears the latch. The latch reads back as status bit 1.
- R3: A status write made while the write-enable latch is clear leaves the status unchanged.
- R4: A frame whose rising-edge count differs from the instruction's exact length leaves the status bits and the latch unchanged. For opcode 0x06 that length is 8, and for opcode 0x01 it is 16.
- R5: Opcode 0x05 drives the status byte on SO, MSB first, with each bit driven on the falling SCK edge, starting with the falling edge after the opcode. so_oe is high while the bits are out. The byte layout is {WPEN, 0, 0, 0, BP1, BP0, WEL, 0}.
- R6: so_oe is low while CS_n is high, and it stays low throughout a status-write frame.
- R7: The block-protect code protects a range of addresses as follows: code 00 protects none, 01 protects 0x300 to 0x3FF, 10 protects 0x200 to 0x3FF, and 11 protects 0x000 to 0x3FF.
- R8: When wp_n is 0 and WPEN is 1, a status write is ignored and the write-enable latch stays set.
- R9: When wp_n is 1, or when WPEN is 0, the status write proceeds as in R1.
- R10: qpermit equals WEL AND NOT (qaddr lies inside the protected range). The hardware lock of R8 does not affect qpermit.
- R11: After reset the status bits and the latch are 0, so_oe is 0 and qpermit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| si | input | 1 | SPI serial data in |
| so | output | 1 | SPI serial data out |
| so_oe | output | 1 | Output enable for so; when low, the pin is high-impedance |
| wp_n | input | 1 | Write-protect pin, active low |
| qaddr | input | 10 | Array address queried by the write path |
| qpermit | output | 1 | High when an array write to qaddr is allowed |

## Verification
The permit output is swept over all 1024 addresses for each of the four block-protect codes, with the latch both set and clear. This separates the quarter boundary from the half boundary and shows that the latch gates every address. Status writes are tried in every combination of pin level, WPEN value and latch state, which tells the hardware lock apart from the missing-latch case. Frames that are one bit short, one bit long or a whole byte long check that only exact-length frames commit. Read-backs of an all-ones write show that the unused bit positions stay zero.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
    localparam int BYTE_W = 8;
    localparam int POS_W  = $clog2(BYTE_W);
    localparam int ADDR_W = 10;

    localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;
    localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
    } nvstat_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic cs_rise;
        logic cs_hi;
        logic si;
    } spi_ev_t;

    // protected-region decode from the two top address bits
    function automatic logic in_region(input logic [1:0] bp, input logic [1:0] top2);
        case (bp)
            2'b00:   in_region = 1'b0;
            2'b01:   in_region = (top2 == 2'b11);
            2'b10:   in_region = top2[1];
            default: in_region = 1'b1;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input nvstat_t s, input logic wel);
        pack_status = {s.wpen, 3'b000, s.bp, wel, 1'b0};
    endfunction
endpackage

// File: rtl/spi_wp_frontend.sv
module spi_wp_frontend
    import spi_wp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sck,
    input  logic    cs_n,
    input  logic    si,
    output spi_ev_t ev
);
    logic sck_d, sck_q, cs_d, cs_q, si_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            sck_q <= 1'b0;
            cs_d  <= 1'b1;
            cs_q  <= 1'b1;
            si_d  <= 1'b0;
        end else begin
            sck_d <= sck;
            sck_q <= sck_d;
            cs_d  <= cs_n;
            cs_q  <= cs_d;
            si_d  <= si;
        end
    end

    always_comb begin
        ev.rise    = sck_d & ~sck_q & ~cs_d;
        ev.fall    = ~sck_d & sck_q & ~cs_d;
        ev.cs_rise = cs_d & ~cs_q;
        ev.cs_hi   = cs_d;
        ev.si      = si_d;
    end
endmodule

// File: rtl/spi_wp_deser.sv
module spi_wp_deser
    import spi_wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              cs_hi,
    input  logic              si,
    output logic [BYTE_W-1:0] opcode,
    output nvstat_t           wr_nv,
    output logic [POS_W-1:0]  bitpos,
    output logic [1:0]        nbytes
);
    localparam logic [POS_W-1:0] LAST = POS_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] nxt;

    assign nxt = {sh[BYTE_W-2:0], si};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            bitpos <= '0;
            nbytes <= '0;
            opcode <= '0;
            wr_nv  <= '0;
        end else if (cs_hi) begin
            sh     <= '0;
            bitpos <= '0;
            nbytes <= '0;
            opcode <= '0;
        end else if (rise) begin
            sh <= nxt;
            if (bitpos == LAST) begin
                bitpos <= '0;
                if (nbytes == 2'd0) opcode <= nxt;
                if (nbytes == 2'd1) wr_nv  <= '{wpen: nxt[7], bp: nxt[3:2]};
                if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
            end else begin
                bitpos <= bitpos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_wp_status.sv
module spi_wp_status
    import spi_wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n,
    input  logic              fall,
    input  logic              cs_rise,
    input  logic              cs_hi,
    input  logic [BYTE_W-1:0] opcode,
    input  nvstat_t           wr_nv,
    input  logic [POS_W-1:0]  bitpos,
    input  logic [1:0]        nbytes,
    output nvstat_t           nv,
    output logic              wel,
    output logic              so,
    output logic              so_oe
);
    logic              hw_lock;
    logic              exact1, exact2;
    logic [BYTE_W-1:0] stat;
    logic [POS_W-1:0]  idx;

    assign hw_lock = ~wp_n & nv.wpen;
    assign exact1  = (bitpos == '0) && (nbytes == 2'd1);
    assign exact2  = (bitpos == '0) && (nbytes == 2'd2);
    assign stat    = pack_status(nv, wel);
    assign idx     = POS_W'(BYTE_W - 1) - bitpos;

    always_ff @(posedge clk) begin
        if (rst) begin
            nv  <= '0;
            wel <= 1'b0;
        end else if (cs_rise) begin
            if (opcode == OP_WREN && exact1)
                wel <= 1'b1;
            if (opcode == OP_WRSR && exact2 && wel && !hw_lock) begin
                nv  <= wr_nv;
                wel <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cs_hi) begin
            so    <= 1'b0;
            so_oe <= 1'b0;
        end else if (fall && opcode == OP_RDSR && nbytes != 2'd0) begin
            so    <= stat[idx];
            so_oe <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_wp_unit.sv
module spi_wp_unit
    import spi_wp_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sck,
    input  logic          cs_n,
    input  logic          si,
    output logic          so,
    output logic          so_oe,
    input  logic          wp_n,
    input  logic [AW-1:0] qaddr,
    output logic          qpermit
);
    spi_ev_t           ev;
    logic [BYTE_W-1:0] opcode;
    nvstat_t           wr_nv;
    nvstat_t           nv;
    logic              wel;
    logic [POS_W-1:0]  bitpos;
    logic [1:0]        nbytes;

    spi_wp_frontend u_fe (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .ev(ev)
    );

    spi_wp_deser u_des (
        .clk(clk), .rst(rst), .rise(ev.rise), .cs_hi(ev.cs_hi), .si(ev.si),
        .opcode(opcode), .wr_nv(wr_nv), .bitpos(bitpos), .nbytes(nbytes)
    );

    spi_wp_status u_st (
        .clk(clk), .rst(rst), .wp_n(wp_n), .fall(ev.fall),
        .cs_rise(ev.cs_rise), .cs_hi(ev.cs_hi), .opcode(opcode),
        .wr_nv(wr_nv), .bitpos(bitpos), .nbytes(nbytes),
        .nv(nv), .wel(wel), .so(so), .so_oe(so_oe)
    );

    assign qpermit = wel & ~in_region(nv.bp, qaddr[AW-1 -: 2]);
endmodule

// File: rtl/spi_wp_unit_chk.sv
module spi_wp_unit_chk
    import spi_wp_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    cs_n,
    input logic    wp_n,
    input logic    so_oe,
    input logic    qpermit,
    input logic    wel,
    input nvstat_t nv
);
    // R6
    so_oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe);

    // R8
    hw_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (!wp_n && nv.wpen) |=> $stable(nv));

    // R2
    wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (nv != $past(nv)) |-> !wel);

    // R10
    permit_wel_chk: assert property (@(posedge clk) disable iff (rst)
        qpermit |-> wel);

    // R7
    full_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (nv.bp == 2'b11) |-> !qpermit);
endmodule

bind spi_wp_unit spi_wp_unit_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n), .so_oe(so_oe),
    .qpermit(qpermit), .wel(wel), .nv(nv)
);

// File: tb/spi_wp_unit_bench.sv
module spi_wp_unit_bench;
    localparam int HP = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       si = 1'b0;
    logic       wp_n = 1'b1;
    logic [9:0] qaddr = '0;
    logic       so, so_oe, qpermit;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_wp_unit u_spi_wp_unit (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .wp_n(wp_n), .qaddr(qaddr), .qpermit(qpermit)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // shift n bits MSB first; capture so on bits 8..15, count so_oe samples
    task automatic frame(input logic [23:0] bits, input int n,
                         output logic [7:0] rx, output int oe_cnt);
        rx = '0;
        oe_cnt = 0;
        cs_n = 1'b0;
        wait_clk(HP);
        for (int i = 0; i < n; i++) begin
            si = bits[23-i];
            wait_clk(HP);
            sck = 1'b1;
            if (i >= 8 && i < 16) rx[15-i] = so;
            if (so_oe) oe_cnt++;
            wait_clk(HP);
            sck = 1'b0;
        end
        wait_clk(HP);
        cs_n = 1'b1;
        wait_clk(4 * HP);
    endtask

    task automatic wren(input int n);
        logic [7:0] rx;
        int oe;
        frame({8'h06, 16'h0}, n, rx, oe);
    endtask

    task automatic wrsr(input logic [7:0] b, input int n, output int oe);
        logic [7:0] rx;
        frame({8'h01, b, 8'h0}, n, rx, oe);
    endtask

    task automatic rdsr(output logic [7:0] v, output int oe);
        frame({8'h05, 16'h0}, 16, v, oe);
    endtask

    task automatic expect_stat(input logic [7:0] exp, input string req);
        logic [7:0] v;
        int oe;
        rdsr(v, oe);
        chk(v == exp, req, v, exp);
    endtask

    task automatic sweep(input int bp, input bit wel_set);
        int bad = 0;
        int lim;
        int first_bad = -1;
        lim = (bp == 0) ? 1024 : (bp == 1) ? 768 : (bp == 2) ? 512 : 0;
        for (int a = 0; a < 1024; a++) begin
            logic exp;
            @(negedge clk);
            qaddr = 10'(a);
            #1;
            exp = wel_set && (a < lim);
            if (qpermit !== exp) begin
                bad++;
                if (first_bad < 0) first_bad = a;
            end
        end
        chk(bad == 0, wel_set ? "R7 region sweep" : "R10 permit without latch",
            first_bad, bp);
    endtask

    initial begin
        logic [7:0] v;
        int oe;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(4);

        // R11 reset state
        chk(so_oe == 1'b0, "R11 so_oe after reset", so_oe, 0);
        chk(qpermit == 1'b0, "R11 qpermit after reset", qpermit, 0);
        rdsr(v, oe);
        chk(v == 8'h00, "R11 status after reset", v, 8'h00);
        chk(oe == 8, "R5 so_oe during read byte", oe, 8);
        chk(so_oe == 1'b0, "R6 so_oe after CS high", so_oe, 0);

        // R3 write without latch
        wrsr(8'h8C, 16, oe);
        expect_stat(8'h00, "R3 write without latch");

        // R2 latch set
        wren(8);
        expect_stat(8'h02, "R2 latch reads as bit 1");

        // R1 commit, R5 unused bits zero, R6 no drive during write
        wrsr(8'hFF, 16, oe);
        chk(oe == 0, "R6 so_oe during status write", oe, 0);
        expect_stat(8'h8C, "R1 commit and R2 latch cleared");

        // R8 hardware lock
        wp_n = 1'b0;
        wren(8);
        wrsr(8'h00, 16, oe);
        expect_stat(8'h8E, "R8 locked write ignored");

        // R9 pin high releases the lock
        wp_n = 1'b1;
        wrsr(8'h00, 16, oe);
        expect_stat(8'h00, "R9 pin high allows write");

        // R9 WPEN low releases the lock
        wp_n = 1'b0;
        wren(8);
        wrsr(8'h04, 16, oe);
        expect_stat(8'h04, "R9 WPEN low allows write");

        // R10 lock does not block array permit
        wren(8);
        wrsr(8'h80, 16, oe);
        wren(8);
        expect_stat(8'h82, "R8 locked with latch set");
        @(negedge clk);
        qaddr = 10'h3FF;
        #1;
        chk(qpermit == 1'b1, "R10 lock leaves array permit", qpermit, 1);
        wp_n = 1'b1;
        wrsr(8'h00, 16, oe);
        expect_stat(8'h00, "R9 unlock write");

        // R4 wrong frame lengths
        wren(7);
        expect_stat(8'h00, "R4 short enable frame");
        wren(9);
        expect_stat(8'h00, "R4 long enable frame");
        wren(8);
        wrsr(8'h8C, 15, oe);
        expect_stat(8'h02, "R4 write frame 15 bits");
        wrsr(8'h8C, 17, oe);
        expect_stat(8'h02, "R4 write frame 17 bits");
        wrsr(8'h8C, 24, oe);
        expect_stat(8'h02, "R4 write frame 24 bits");

        // R7 / R10 permit sweeps per protect code
        for (int bp = 0; bp < 4; bp++) begin
            wren(8);
            wrsr(8'(bp << 2), 16, oe);
            sweep(bp, 1'b0);
            wren(8);
            sweep(bp, 1'b1);
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule